// File: doc/BRIEF.md
# Priority Age-Matrix Replay Selector

This block decides, once per cycle and independently in each bank, which entry of a load replay queue is sent back to a load pipeline. The queue's entries are split evenly into banks. Each bank keeps an age matrix, driven by the enqueue and dequeue strobes, that records which of its live entries arrived first.

Selection runs through four tiers in a fixed order. The first tier holds ready entries that an early cache-miss hint has woken. The second holds ready entries whose replay cause is high priority (a cache miss or a store-to-load forwarding problem). The third holds any other ready entry. The last tier is the fallback: when no live entry is ready, the longest-resident live entry is chosen. Inside the winning tier, the age matrix picks the entry that has been in the queue longest.

The caller computes readiness and passes it in as `ready_i`. An entry is ready when it is allocated, not already scheduled, and not blocked waiting for a wake-up. The winning local index is registered, so each bank's grant comes one cycle after the inputs that produced it.

Top module: `rsel_replay_sel`

## Requirements
- R1: After reset every bank's queue is empty and `sel_valid_o` is 0. A bank with no live entries drives `sel_valid_o` 0.
- R2: A live entry whose `ready_i` and `hint_i` bits are both set is chosen ahead of every other live entry in its bank, whatever their causes or ages.
- R3: When no hint-woken entry is ready, a ready entry with `hi_cause_i` set is chosen ahead of ready entries with `hi_cause_i` clear, even if those arrived earlier.
- R4: Within the winning tier, the entry that was enqueued earliest is chosen. Entry index plays no part in this.
- R5: When a bank has live entries but none of them is ready, the earliest-enqueued live entry is chosen and `sel_valid_o` is 1.
- R6: A `deq_i` pulse removes the entry at that clock edge. From then on the entry is never chosen, and the relative order of the remaining entries is unchanged.
- R7: When several entries of one bank are enqueued in the same cycle, the lower index counts as older. All of them count as younger than entries that were already live.
- R8: Global entry e belongs to bank e / BANK_ENTRIES. Its local index is e % BANK_ENTRIES. Each bank's local index is packed at bits [b*IDX_W +: IDX_W] of `sel_idx_o`. The banks do not affect one another.
- R9: The grant changes at the first rising clock edge after the inputs change, and not before that edge. The grant is computed from the queue contents as they stood before that edge.
- R10: `ready_i`, `hint_i` and `hi_cause_i` bits of entries that are not live are ignored. A hint bit without its ready bit is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_i | input | NUM_BANKS*BANK_ENTRIES | Per-entry enqueue strobe; the entry becomes live |
| deq_i | input | NUM_BANKS*BANK_ENTRIES | Per-entry dequeue strobe; the entry is released |
| ready_i | input | NUM_BANKS*BANK_ENTRIES | Entry is ready for replay |
| hint_i | input | NUM_BANKS*BANK_ENTRIES | Entry was woken by an early miss hint |
| hi_cause_i | input | NUM_BANKS*BANK_ENTRIES | Entry's replay cause is high priority |
| sel_valid_o | output | NUM_BANKS | Bank has a grant |
| sel_idx_o | output | NUM_BANKS*IDX_W | Granted local index per bank |

## Verification
Every grant is due exactly one rising edge after the inputs that cause it, and it reflects the queue contents from before that edge. An enqueue or dequeue applied on a row therefore first influences the grant of the following row. The bench drives each row just after a falling edge and holds it across one rising edge. It clears the inputs and samples shortly after that rising edge, so every row sees exactly one edge. A directed test samples before and after the edge to show that the grant does not move early.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  typedef enum logic [1:0] {
    TIER_HINT   = 2'd0,
    TIER_HI     = 2'd1,
    TIER_LO     = 2'd2,
    TIER_OLDEST = 2'd3
  } tier_e;
endpackage

// File: rtl/rsel_age_matrix.sv
module rsel_age_matrix #(
  parameter int E = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [E-1:0]        enq_i,
  input  logic [E-1:0]        deq_i,
  output logic [E-1:0]        live_o,
  output logic [E-1:0][E-1:0] older_o  // older_o[i][j]: j arrived before i
);
  logic [E-1:0]        live_q;
  logic [E-1:0][E-1:0] m_q, m_d;

  always_comb begin
    m_d = m_q;
    for (int i = 0; i < E; i++) begin
      for (int j = 0; j < E; j++) begin
        if (i == j || deq_i[i] || deq_i[j]) m_d[i][j] = 1'b0;
        else if (enq_i[i])                  m_d[i][j] = live_q[j] | (enq_i[j] && j < i);
        else if (enq_i[j])                  m_d[i][j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      m_q    <= '0;
    end else begin
      live_q <= (live_q & ~deq_i) | enq_i;
      m_q    <= m_d;
    end
  end

  assign live_o  = live_q;
  assign older_o = m_q;

  // every pair of live entries must be strictly ordered
  logic order_ok;
  always_comb begin
    order_ok = 1'b1;
    for (int i = 0; i < E; i++)
      for (int j = 0; j < E; j++)
        if (i != j && live_q[i] && live_q[j] && (m_q[i][j] == m_q[j][i])) order_ok = 1'b0;
  end

  p_total_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) order_ok);
endmodule

// File: rtl/rsel_tier_pick.sv
module rsel_tier_pick
  import rsel_pkg::*;
#(
  parameter int E = 8
) (
  input  logic [E-1:0]        live_i,
  input  logic [E-1:0]        ready_i,
  input  logic [E-1:0]        hint_i,
  input  logic [E-1:0]        hi_i,
  input  logic [E-1:0][E-1:0] older_i,
  output logic [E-1:0]        grant_o,
  output logic                any_o,
  output tier_e               tier_o
);
  logic [E-1:0] rdy, mask;

  always_comb begin
    rdy = live_i & ready_i;
    if (|(rdy & hint_i)) begin
      mask = rdy & hint_i; tier_o = TIER_HINT;
    end else if (|(rdy & hi_i)) begin
      mask = rdy & hi_i;   tier_o = TIER_HI;
    end else if (|rdy) begin
      mask = rdy;          tier_o = TIER_LO;
    end else begin
      mask = live_i;       tier_o = TIER_OLDEST;
    end
    any_o = |mask;
    for (int i = 0; i < E; i++)
      grant_o[i] = mask[i] & ~|(older_i[i] & mask);
  end
endmodule

// File: rtl/rsel_bank.sv
module rsel_bank
  import rsel_pkg::*;
#(
  parameter int E    = 8,
  parameter int IW   = $clog2(E)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [E-1:0]  enq_i,
  input  logic [E-1:0]  deq_i,
  input  logic [E-1:0]  ready_i,
  input  logic [E-1:0]  hint_i,
  input  logic [E-1:0]  hi_i,
  output logic          sel_valid_o,
  output logic [IW-1:0] sel_idx_o
);
  logic [E-1:0]        live;
  logic [E-1:0][E-1:0] older;
  logic [E-1:0]        grant;
  logic                any;
  tier_e               tier;
  logic [IW-1:0]       enc;

  rsel_age_matrix #(.E(E)) u_age (
    .clk_i, .rst_ni, .enq_i, .deq_i, .live_o(live), .older_o(older)
  );

  rsel_tier_pick #(.E(E)) u_pick (
    .live_i(live), .ready_i, .hint_i, .hi_i, .older_i(older),
    .grant_o(grant), .any_o(any), .tier_o(tier)
  );

  always_comb begin
    enc = '0;
    for (int i = 0; i < E; i++)
      if (grant[i]) enc = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
    end else begin
      sel_valid_o <= any;
      sel_idx_o   <= enc;
    end
  end

  logic [E-1:0] hint_cand;
  assign hint_cand = live & ready_i & hint_i;

  p_grant_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any == (|grant)));
  p_hint_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hint_cand) |=> sel_valid_o && (($past(hint_cand) & (E'(1) << sel_idx_o)) != '0));
  p_hint_tier_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hint_cand) |-> tier == TIER_HINT);
  p_empty_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|live) |=> !sel_valid_o);
  p_fallback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|live) |=> sel_valid_o && (($past(live) & (E'(1) << sel_idx_o)) != '0));
endmodule

// File: rtl/rsel_replay_sel.sv
module rsel_replay_sel #(
  parameter int NUM_BANKS    = 3,
  parameter int BANK_ENTRIES = 8,
  parameter int IDX_W        = $clog2(BANK_ENTRIES),
  parameter int N            = NUM_BANKS * BANK_ENTRIES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               enq_i,
  input  logic [N-1:0]               deq_i,
  input  logic [N-1:0]               ready_i,
  input  logic [N-1:0]               hint_i,
  input  logic [N-1:0]               hi_cause_i,
  output logic [NUM_BANKS-1:0]       sel_valid_o,
  output logic [NUM_BANKS*IDX_W-1:0] sel_idx_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_ENTRIES;
    rsel_bank #(.E(BANK_ENTRIES), .IW(IDX_W)) u_bank (
      .clk_i,
      .rst_ni,
      .enq_i      (enq_i[LO +: BANK_ENTRIES]),
      .deq_i      (deq_i[LO +: BANK_ENTRIES]),
      .ready_i    (ready_i[LO +: BANK_ENTRIES]),
      .hint_i     (hint_i[LO +: BANK_ENTRIES]),
      .hi_i       (hi_cause_i[LO +: BANK_ENTRIES]),
      .sel_valid_o(sel_valid_o[b]),
      .sel_idx_o  (sel_idx_o[b*IDX_W +: IDX_W])
    );
  end
endmodule

// File: tb/tb_rsel_replay_sel.sv
module tb_rsel_replay_sel;
  localparam int NB = 3, E = 8, IW = 3, N = NB * E, ROWS = 13;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] enq, deq, rdy, hint, hi;
  logic [NB-1:0] sel_valid;
  logic [NB*IW-1:0] sel_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rsel_replay_sel #(.NUM_BANKS(NB), .BANK_ENTRIES(E)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enq_i(enq), .deq_i(deq), .ready_i(rdy),
    .hint_i(hint), .hi_cause_i(hi), .sel_valid_o(sel_valid), .sel_idx_o(sel_idx)
  );

  // Expected results follow R2-R10; bank b owns entries b*8..b*8+7
  localparam logic [23:0] T_ENQ [ROWS] = '{24'h000408, 24'h020022, 0, 0, 0, 0, 0, 0, 0, 0, 24'h000080, 24'h000001, 0};
  localparam logic [23:0] T_DEQ [ROWS] = '{0, 0, 0, 0, 0, 0, 24'h000008, 0, 24'h020422, 0, 0, 0, 0};
  localparam logic [23:0] T_RDY [ROWS] = '{0, 0, 0, 24'h000222, 24'h000022, 24'h00042A, 0, 0, 0, 0, 0, 0, 24'h100081};
  localparam logic [23:0] T_HNT [ROWS] = '{0, 0, 0, 24'h020000, 0, 24'h000020, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [23:0] T_HI  [ROWS] = '{0, 0, 0, 0, 24'h000020, 24'h000008, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [2:0]  X_V   [ROWS] = '{3'b000, 3'b011, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b000, 3'b000, 3'b001, 3'b001};
  localparam logic [8:0]  X_IDX [ROWS] = '{9'o000, 9'o023, 9'o123, 9'o121, 9'o125, 9'o125, 9'o123, 9'o121, 9'o121, 9'o000, 9'o000, 9'o007, 9'o007};
  localparam string       T_REQ [ROWS] = '{"R1", "R5 R8", "R5", "R4 R7 R10", "R3", "R2", "R6", "R6", "R6", "R6 R1", "R1", "R5", "R4 R10"};

  task automatic clear_in();
    enq = '0; deq = '0; rdy = '0; hint = '0; hi = '0;
  endtask

  task automatic check(input string req, input logic [2:0] ev, input logic [8:0] ei);
    total++;
    if (sel_valid !== ev) begin
      bad++; $display("FAIL %s valid act=%b exp=%b", req, sel_valid, ev);
    end else begin
      for (int b = 0; b < NB; b++)
        if (ev[b] && sel_idx[b*IW +: IW] !== ei[b*IW +: IW]) begin
          bad++; $display("FAIL %s bank%0d idx act=%0d exp=%0d", req, b, sel_idx[b*IW +: IW], ei[b*IW +: IW]);
        end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 check("R1", 3'b000, 9'o0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check("R1", 3'b000, 9'o0);

    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      enq = T_ENQ[r]; deq = T_DEQ[r]; rdy = T_RDY[r]; hint = T_HNT[r]; hi = T_HI[r];
      @(posedge clk); #1 clear_in();
      check(T_REQ[r], X_V[r], X_IDX[r]);
    end

    // R9: live bank0 {7 older, 0}; only 0 ready -> grant moves to 0 after one edge
    @(negedge clk); rdy = 24'h000001;
    #1 check("R9", 3'b001, 9'o007);
    @(posedge clk); #1 clear_in();
    check("R9", 3'b001, 9'o000);

    // R10: hint without ready ignored -> fallback oldest 7
    @(negedge clk); hint = 24'h000001;
    @(posedge clk); #1 clear_in();
    check("R10", 3'b001, 9'o007);

    // R1: reset mid-run empties the queue
    @(negedge clk) rst_ni = 1'b0;
    #1 check("R1", 3'b000, 9'o0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check("R1", 3'b000, 9'o0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule